// File: doc/BRIEF.md
# Iterative DES Round Datapath

This block is the ciphering engine of a DES unit that is folded down to a single round. It accepts one 64-bit block with a start strobe and applies the initial bit permutation. It then runs the sixteen Feistel rounds, one per clock. On each of those clocks it reads a 48-bit round subkey from an external key schedule, and it tells that schedule which round index it wants. After the last round it swaps the halves, applies the inverse permutation, and presents the 64-bit result together with a one-cycle done pulse.

The eight substitution boxes are synchronous read-only memories, arranged as four dual-port memories with two boxes each. Their outputs are registered, so the round state register sits after the substitution stage rather than before it. The feedback path therefore runs from the registered box outputs through the permutation, the XOR with the held left half, the expansion and the key XOR, and back into the memory addresses. Decryption uses exactly the same datapath: the key schedule presents the subkeys in reverse order.

Top module: `des_round_core`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0 and block_o is all zeros.
- R2: A start_i sampled while busy_o is 0 is accepted. In that clock, round_idx_o is 0 and subkey_i is taken as the subkey of round 1. On the 15 following clocks, round_idx_o reads 1, 2, ... 15 and subkey_i is taken for rounds 2 to 16. round_idx_o is 0 whenever busy_o is 0.
- R3: done_o rises exactly 17 rising edges after the edge that accepted start_i, counting that edge as the first. It stays high for exactly one clock.
- R4: busy_o is 1 from the edge after acceptance up to the edge that raises done_o, and it is 0 while done_o is 1.
- R5: A start_i that arrives while busy_o is 1 is ignored. The running block's timing and result are unchanged, and changes on block_i after the accepting edge have no effect.
- R6: With subkeys K1..K16 of the standard DES key schedule presented for index 0..15, block_o equals the DES encryption of block_i. Bit 63 of every 64-bit bus is DES bit 1, and bit 47 of subkey_i is subkey bit 1.
- R7: If the same subkeys are presented in reverse order (index i carries K16-i), block_o equals the DES decryption, so a ciphertext returns its plaintext.
- R8: block_o changes only on the edge that raises done_o, and it holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a block; sampled only when idle |
| block_i | input | 64 | Input block, captured on the accepting edge |
| subkey_i | input | 48 | Subkey for the round selected by round_idx_o |
| round_idx_o | output | 4 | Zero-based index of the round whose subkey is consumed this clock |
| busy_o | output | 1 | High while a block is in flight |
| done_o | output | 1 | One-cycle pulse marking a new result on block_o |
| block_o | output | 64 | Result block, held until the next done pulse |

## Verification
The assertions assume that start_i is a clean level, sampled only at rising edges, and that the environment supplies a subkey for whatever index round_idx_o shows. They also assume reset is held for at least one edge before any request. The bench meets these assumptions in the following way. It drives every input on the falling edge. It derives subkey_i combinationally from round_idx_o through a key schedule of its own, and it raises start only while the block is idle, except in the cycles that deliberately probe the ignore rule.

// File: rtl/des_pkg.sv
package des_pkg;

    localparam int unsigned BLK_W   = 64;
    localparam int unsigned HALF_W  = BLK_W / 2;
    localparam int unsigned SUB_W   = 48;
    localparam int unsigned GRP_W   = 6;
    localparam int unsigned NIB_W   = 4;
    localparam int unsigned NBOX    = SUB_W / GRP_W;
    localparam int unsigned NPAIR   = NBOX / 2;
    localparam int unsigned ROUNDS  = 16;
    localparam int unsigned CNT_W   = $clog2(ROUNDS);

    // Source position (1 = most significant) for each output position.
    localparam int unsigned IP_TAB [64] = '{
        58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
        62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
        57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
        61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};

    localparam int unsigned FP_TAB [64] = '{
        40,8,48,16,56,24,64,32, 39,7,47,15,55,23,63,31,
        38,6,46,14,54,22,62,30, 37,5,45,13,53,21,61,29,
        36,4,44,12,52,20,60,28, 35,3,43,11,51,19,59,27,
        34,2,42,10,50,18,58,26, 33,1,41,9,49,17,57,25};

    localparam int unsigned EX_TAB [48] = '{
        32,1,2,3,4,5,     4,5,6,7,8,9,       8,9,10,11,12,13,
        12,13,14,15,16,17, 16,17,18,19,20,21, 20,21,22,23,24,25,
        24,25,26,27,28,29, 28,29,30,31,32,1};

    localparam int unsigned PM_TAB [32] = '{
        16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
        2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};

    // Substitution tables, row-major: index = {outer bits, inner bits}.
    localparam int unsigned SB0 [64] = '{
        14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,
        0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
        4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,
        15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
    localparam int unsigned SB1 [64] = '{
        15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,
        3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
        0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,
        13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
    localparam int unsigned SB2 [64] = '{
        10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,
        13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
        13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,
        1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
    localparam int unsigned SB3 [64] = '{
        7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,
        13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
        10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,
        3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
    localparam int unsigned SB4 [64] = '{
        2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,
        14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
        4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,
        11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
    localparam int unsigned SB5 [64] = '{
        12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,
        10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
        9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,
        4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
    localparam int unsigned SB6 [64] = '{
        4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,
        13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
        1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,
        6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
    localparam int unsigned SB7 [64] = '{
        13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,
        1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
        7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,
        2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

    function automatic logic [3:0] sbox_lookup(input int unsigned box, input logic [5:0] grp);
        int unsigned idx;
        idx = int'({grp[5], grp[0], grp[4:1]});
        case (box)
            0:       return 4'(SB0[idx]);
            1:       return 4'(SB1[idx]);
            2:       return 4'(SB2[idx]);
            3:       return 4'(SB3[idx]);
            4:       return 4'(SB4[idx]);
            5:       return 4'(SB5[idx]);
            6:       return 4'(SB6[idx]);
            default: return 4'(SB7[idx]);
        endcase
    endfunction

    function automatic logic [63:0] perm_init(input logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[63-i] = x[64-IP_TAB[i]];
        return y;
    endfunction

    function automatic logic [63:0] perm_final(input logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[63-i] = x[64-FP_TAB[i]];
        return y;
    endfunction

    function automatic logic [47:0] expand_half(input logic [31:0] x);
        logic [47:0] y;
        for (int i = 0; i < 48; i++) y[47-i] = x[32-EX_TAB[i]];
        return y;
    endfunction

    function automatic logic [31:0] perm_mix(input logic [31:0] x);
        logic [31:0] y;
        for (int i = 0; i < 32; i++) y[31-i] = x[32-PM_TAB[i]];
        return y;
    endfunction

    typedef struct packed {
        logic [HALF_W-1:0] lprev;
        logic [HALF_W-1:0] rprev;
        logic [BLK_W-1:0]  dout;
        logic              done;
    } core_st_t;

endpackage

// File: rtl/des_sbox_pair_rom.sv
module des_sbox_pair_rom
    import des_pkg::*;
#(
    parameter int unsigned BOX_A = 0,
    parameter int unsigned BOX_B = 1
) (
    input  logic             clk,
    input  logic             en,
    input  logic [GRP_W-1:0] addr_a,
    input  logic [GRP_W-1:0] addr_b,
    output logic [NIB_W-1:0] data_a,
    output logic [NIB_W-1:0] data_b
);

    // Registered read ports, no reset, as an embedded memory behaves.
    always_ff @(posedge clk) begin
        if (en) begin
            data_a <= sbox_lookup(BOX_A, addr_a);
            data_b <= sbox_lookup(BOX_B, addr_b);
        end
    end

endmodule

// File: rtl/des_round_seq.sv
module des_round_seq
    import des_pkg::*;
#(
    parameter int unsigned NROUND = ROUNDS,
    localparam int unsigned CW    = $clog2(NROUND)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          load_o,
    output logic          issue_o,
    output logic          finish_o,
    output logic          busy_o,
    output logic [CW-1:0] round_idx_o
);

    localparam logic [CW-1:0] LAST = CW'(NROUND - 1);

    typedef struct packed {
        logic          busy;
        logic          fin;
        logic [CW-1:0] cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    accept;

    always_comb begin
        st_d   = st_q;
        accept = start_i && !st_q.busy && !st_q.fin;
        st_d.fin = 1'b0;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(1);
        end else if (st_q.busy) begin
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.fin  = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_o      = accept;
    assign issue_o     = accept || st_q.busy;
    assign finish_o    = st_q.fin;
    assign busy_o      = st_q.busy || st_q.fin;
    assign round_idx_o = st_q.busy ? st_q.cnt : '0;

endmodule

// File: rtl/des_round_core.sv
module des_round_core
    import des_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [63:0] block_i,
    input  logic [47:0] subkey_i,
    output logic [3:0]  round_idx_o,
    output logic        busy_o,
    output logic        done_o,
    output logic [63:0] block_o
);

    core_st_t           st_d, st_q;
    logic               load, issue, finish;
    logic [HALF_W-1:0]  sbox_q;
    logic [HALF_W-1:0]  r_fb;
    logic [HALF_W-1:0]  l_cur, r_cur;
    logic [BLK_W-1:0]   ip_blk;
    logic [SUB_W-1:0]   mix_key;

    des_round_seq #(.NROUND(ROUNDS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .load_o      (load),
        .issue_o     (issue),
        .finish_o    (finish),
        .busy_o      (busy_o),
        .round_idx_o (round_idx_o)
    );

    // Right half rebuilt from the registered substitution output.
    assign r_fb    = st_q.lprev ^ perm_mix(sbox_q);
    assign ip_blk  = perm_init(block_i);
    assign l_cur   = load ? ip_blk[63:32] : st_q.rprev;
    assign r_cur   = load ? ip_blk[31:0]  : r_fb;
    assign mix_key = expand_half(r_cur) ^ subkey_i;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        des_sbox_pair_rom #(.BOX_A(2*p), .BOX_B(2*p+1)) u_rom (
            .clk    (clk),
            .en     (issue),
            .addr_a (mix_key[SUB_W-1-12*p -: GRP_W]),
            .addr_b (mix_key[SUB_W-7-12*p -: GRP_W]),
            .data_a (sbox_q[HALF_W-1-8*p -: NIB_W]),
            .data_b (sbox_q[HALF_W-5-8*p -: NIB_W])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = finish;
        if (issue) begin
            st_d.lprev = l_cur;
            st_d.rprev = r_cur;
        end
        if (finish) begin
            st_d.dout = perm_final({r_fb, st_q.rprev});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o  = st_q.done;
    assign block_o = st_q.dout;

endmodule

// File: rtl/des_round_core_chk.sv
module des_round_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [3:0]  round_idx_o,
    input logic        busy_o,
    input logic        done_o,
    input logic [63:0] block_o
);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_idle_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> round_idx_o == 4'd0);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && round_idx_o == 4'd1));

    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && round_idx_o >= 4'd1 && round_idx_o <= 4'd14)
        |=> round_idx_o == $past(round_idx_o) + 4'd1);

    p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && round_idx_o != 4'd0) |=> (busy_o && !done_o));

    p_done_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(block_o));

endmodule

bind des_round_core des_round_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .round_idx_o (round_idx_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .block_o     (block_o)
);

// File: tb/tb_des_round_core.sv
module tb_des_round_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] block_i = '0;
    logic [47:0] subkey_i;
    logic [3:0]  round_idx_o;
    logic        busy_o, done_o;
    logic [63:0] block_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit ended   = 1'b0;

    logic [47:0] ks [16];
    bit          dec_mode = 1'b0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    des_round_core dut (.*);

    always #2.5 clk = ~clk;

    always_comb subkey_i = dec_mode ? ks[15 - int'(round_idx_o)] : ks[int'(round_idx_o)];

    localparam int unsigned PC1 [56] = '{
        57,49,41,33,25,17,9,1,58,50,42,34,26,18,10,2,59,51,43,35,27,19,11,3,60,52,44,36,
        63,55,47,39,31,23,15,7,62,54,46,38,30,22,14,6,61,53,45,37,29,21,13,5,28,20,12,4};
    localparam int unsigned PC2 [48] = '{
        14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
        41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};
    localparam int unsigned SHF [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

    task automatic make_keys(input logic [63:0] key);
        logic [55:0] k56;
        logic [27:0] c, d;
        for (int i = 0; i < 56; i++) k56[55-i] = key[64-PC1[i]];
        c = k56[55:28];
        d = k56[27:0];
        for (int r = 0; r < 16; r++) begin
            for (int s = 0; s < int'(SHF[r]); s++) begin
                c = {c[26:0], c[27]};
                d = {d[26:0], d[27]};
            end
            for (int i = 0; i < 48; i++) ks[r][47-i] = {c, d}[56-PC2[i]];
        end
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    // Runs one block; inject_at > 0 raises start_i at that cycle of the run.
    task automatic run_block(input logic [63:0] key, input logic [63:0] din, input bit dec,
                             input int inject_at, output logic [63:0] res);
        int lat;
        bit idx_ok, busy_ok;
        logic [63:0] held;
        make_keys(key);
        dec_mode = dec;
        @(negedge clk);
        block_i = din;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        block_i = ~din;
        lat = 1; idx_ok = 1'b1; busy_ok = 1'b1;
        while (!done_o && lat < 40) begin
            if (lat <= 15 && round_idx_o != 4'(lat)) idx_ok = 1'b0;
            if (lat == 16 && round_idx_o != 4'd0) idx_ok = 1'b0;
            if (!busy_o) busy_ok = 1'b0;
            if (lat == inject_at) start_i = 1'b1;
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end
        check(idx_ok, "R2 round index sequence", 64'(round_idx_o), 64'(0));
        check(lat == 17, "R3 done latency", 64'(lat), 64'd17);
        check(busy_ok && !busy_o, "R4 busy window", 64'(busy_o), 64'd0);
        res  = block_o;
        held = block_o;
        @(negedge clk);
        check(!done_o, "R3 done one cycle", 64'(done_o), 64'd0);
        check(block_o == held, "R8 output held", block_o, held);
    endtask

    task automatic kat(input logic [63:0] key, input logic [63:0] pt, input logic [63:0] ct);
        logic [63:0] r;
        run_block(key, pt, 1'b0, 0, r);
        check(r == ct, "R6 encrypt known answer", r, ct);
        run_block(key, ct, 1'b1, 0, r);
        check(r == pt, "R7 decrypt known answer", r, pt);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] r, c, key, pt, held;
        make_keys(64'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o, "R1 reset busy", 64'(busy_o), 64'd0);
        check(!done_o, "R1 reset done", 64'(done_o), 64'd0);
        check(block_o == 64'h0, "R1 reset output", block_o, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(round_idx_o == 4'd0, "R2 idle index", 64'(round_idx_o), 64'd0);

        kat(64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 64'h85E813540F0AB405);
        kat(64'h0000000000000000, 64'h0000000000000000, 64'h8CA64DE9C1B123A7);
        kat(64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h7359B2163E4EDC58);
        kat(64'h0123456789ABCDEF, 64'h4E6F772069732074, 64'h3FA40E8A984D4815);

        // R5: start raised mid-run and in the finishing cycle is ignored.
        run_block(64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 1'b0, 5, r);
        check(r == 64'h85E813540F0AB405, "R5 start while busy (mid)", r, 64'h85E813540F0AB405);
        run_block(64'h133457799BBCDFF1, 64'h0123456789ABCDEF, 1'b0, 16, r);
        check(r == 64'h85E813540F0AB405, "R5 start while busy (last)", r, 64'h85E813540F0AB405);
        @(negedge clk);
        check(!busy_o && !done_o, "R5 no extra run", 64'({busy_o, done_o}), 64'd0);

        // R8: output holds across idle cycles with changing inputs.
        held = block_o;
        for (int i = 0; i < 6; i++) begin
            block_i = next_rand(block_i);
            @(negedge clk);
        end
        check(block_o == held, "R8 idle hold", block_o, held);

        // R7: round trips over a single-bit walk and a random sweep.
        for (int b = 0; b < 64; b++) begin
            pt = 64'h1 << b;
            run_block(64'h0E329232EA6D0D73, pt, 1'b0, 0, c);
            run_block(64'h0E329232EA6D0D73, c, 1'b1, 0, r);
            check(r == pt && c != pt, "R7 round trip bit walk", r, pt);
        end
        for (int n = 0; n < 40; n++) begin
            rng = next_rand(rng); key = rng;
            rng = next_rand(rng); pt = rng;
            run_block(key, pt, 1'b0, 0, c);
            run_block(key, c, 1'b1, 0, r);
            check(r == pt, "R7 round trip random", r, pt);
        end

        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule